// File: doc/BRIEF.md
# Multi-Game Cartridge Outer Bank Mapper

This block turns CPU and PPU addresses into ROM bank numbers for a cartridge that holds several games. Four outer configuration registers choose which of three inner banking personalities is active. They also set a base position for the selected game inside the large ROM and set how many low bank bits the inner personality may drive. Every bank number is the inner bank combined with the outer base: the bits inside a mask come from the inner bank and the bits outside it come from the base.

The inner personalities keep their own register files and interrupt logic outside this block. The block only receives their current bank values and mode bits. It supports three personalities: a scanline-counter style with four 8 KiB program windows, a serial-load style with 16/32 KiB program and 4/8 KiB character banking, and a cycle-counter style that also uses 8 KiB windows. Two override bits can replace the program or character mapping with one fixed bank taken from the outer base. A readable switch value, which steps on every system reset, lets a menu program present a different game set.

All bank outputs are combinational in the registers and the current address, so a register write takes effect on the first access after the write edge.

Top module: `mc_outer_mapper`

## Requirements
- R1: A write with `cpu_wr` high and `cpu_addr[15:12]` equal to 4'h5 stores `cpu_wdata` in outer register `cpu_addr[1:0]` at the clock edge. Writes to any other address leave all four registers unchanged.
- R2: While `cpu_rd` is high and `cpu_addr[15:12]` is 4'h5, `cpu_rdata` shows the switch value. At all other times `cpu_rdata` is zero.
- R3: Register 0 bits [1:0] choose the personality: 0 or 1 selects scanline-counter, 2 selects serial-load, 3 selects cycle-counter.
- R4: The program base is register 1 shifted right by one. The program mask is 8'h0F when register 2 bit 2 is set and 8'h1F when it is clear. Every program bank is (inner & mask) | (base & ~mask).
- R5: In the two 8 KiB personalities, window `cpu_addr[14:13]`=1 uses the second program value and window 3 uses inner bank 8'hFF. With the swap bit clear, window 0 uses the first value and window 2 uses 8'hFE. With the swap bit set, those two are exchanged.
- R6: In the serial-load personality the mask and base are shifted right once more and give a 16 KiB bank. When `se_ctrl[3]` is clear, a 32 KiB bank is used: the blended value without its LSB, combined with `cpu_addr[14:13]`. When `se_ctrl[3]` is set, `se_ctrl[2]`=1 puts `se_prg` low and bank 8'hFF high, and `se_ctrl[2]`=0 puts bank 0 low and `se_prg` high.
- R7: When register 2 bit 7 is set, program mapping is fixed. With bit 2 set, the 16 KiB bank base>>1 appears in both halves. With bit 2 clear, the 32 KiB bank base>>2 is used.
- R8: The character base is register 0 shifted left by one. The character mask is 9'h01F if register 2 bit 4 is set, otherwise 9'h07F if bit 5 is set, otherwise 9'h0FF. In the scanline-counter personality, slot `ppu_addr[12:10]` XOR 4·`sc_chr_swap` selects a value: slots 0–3 use the 2 KiB values 0 and 1 (LSB replaced by the slot LSB), and slots 4–7 use values 2–5. The cycle-counter personality uses `cy_chr[slot]` directly.
- R9: In the serial-load personality the character mask and base are shifted right by two. When `se_ctrl[4]` is set, 4 KiB banks are used (`se_chr_lo` below 0x1000 and `se_chr_hi` above). When it is clear, one 8 KiB bank is formed from `se_chr_lo` without its LSB.
- R10: When register 2 bit 6 is set, character mapping is one fixed 8 KiB bank, base>>3.
- R11: The `mirror` output uses 0 vertical, 1 horizontal, 2 single-screen A, 3 single-screen B. The scanline-counter personality gives `sc_mirror` (0 vertical, 1 horizontal). The cycle-counter personality passes `cy_mirror` through. The serial-load personality gives `se_ctrl[1:0]` XOR 2.
- R12: `rst` clears the four registers and increments the switch value. `pwr_rst` clears the registers and the switch value. `rst` takes priority over a register write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | System reset, synchronous, active high |
| pwr_rst | input | 1 | Power-on reset, synchronous, active high |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Switch value read data |
| ppu_addr | input | 14 | PPU address |
| sc_prg_a | input | 8 | Scanline personality first program value |
| sc_prg_b | input | 8 | Scanline personality second program value |
| sc_prg_swap | input | 1 | Scanline personality program swap bit |
| sc_chr | input | 48 | Six character values, value k in bits [8k+7:8k] |
| sc_chr_swap | input | 1 | Scanline personality character half swap |
| sc_mirror | input | 1 | Scanline personality mirroring bit |
| cy_prg_a | input | 8 | Cycle personality first program value |
| cy_prg_b | input | 8 | Cycle personality second program value |
| cy_prg_swap | input | 1 | Cycle personality program swap bit |
| cy_chr | input | 64 | Eight 1 KiB values, slot k in bits [8k+7:8k] |
| cy_mirror | input | 2 | Cycle personality mirroring code |
| se_ctrl | input | 5 | Serial personality control value |
| se_prg | input | 5 | Serial personality program value |
| se_chr_lo | input | 5 | Serial personality lower character value |
| se_chr_hi | input | 5 | Serial personality upper character value |
| prg_bank | output | 8 | Program bank in 8 KiB units |
| chr_bank | output | 9 | Character bank in 1 KiB units |
| mirror | output | 2 | Nametable arrangement code |

## Verification
A register write can happen in the same cycle as a system reset. The reset has to win, even though the bench drives the write so that it would switch program mapping to the fixed mode. The bench drives both strobes in one cycle with a write of 8'h80 to register 2. It then checks that every program window still follows the cleared registers and that the switch value has stepped by one. A second case is a write whose address lands just outside the register window. The bench judges this case by checking that every bank lookup is unchanged.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [1:0] {
    PERS_SCAN = 2'd0,
    PERS_SER  = 2'd2,
    PERS_CYC  = 2'd3
  } pers_t;

  typedef enum logic [1:0] {
    MIR_VERT  = 2'd0,
    MIR_HORZ  = 2'd1,
    MIR_ONE_A = 2'd2,
    MIR_ONE_B = 2'd3
  } mir_t;

  function automatic pers_t pers_of(input logic [1:0] sel);
    if (!sel[1]) return PERS_SCAN;
    if (!sel[0]) return PERS_SER;
    return PERS_CYC;
  endfunction

  // masked merge of an inner bank with an outer base
  function automatic logic [15:0] mix_bits(input logic [15:0] inner,
                                           input logic [15:0] mask,
                                           input logic [15:0] outer);
    return (inner & mask) | (outer & ~mask);
  endfunction

endpackage

// File: rtl/mc_outer_regs.sv
module mc_outer_regs #(
  parameter int DATA_W = 8,
  parameter int NREG   = 4,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         pwr_rst,
  input  logic                         wr_en,
  input  logic [SEL_W-1:0]             wr_sel,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [NREG-1:0][DATA_W-1:0]  regs_o,
  output logic [DATA_W-1:0]            sw_o
);

  logic [DATA_W-1:0] q [NREG];
  logic [DATA_W-1:0] sw_q;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (pwr_rst || rst)
        q[g] <= '0;
      else if (wr_en && wr_sel == SEL_W'(g))
        q[g] <= wr_data;
    end
    assign regs_o[g] = q[g];
  end

  always_ff @(posedge clk) begin
    if (pwr_rst)
      sw_q <= '0;
    else if (rst)
      sw_q <= sw_q + 1'b1;
  end

  assign sw_o = sw_q;

endmodule

// File: rtl/mc_prg_map.sv
module mc_prg_map
  import mc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SE_W   = 5
) (
  input  pers_t              pers,
  input  logic               fix_en,
  input  logic               small_mask,
  input  logic [DATA_W-1:0]  outer_reg,
  input  logic [1:0]         win,
  input  logic [DATA_W-1:0]  sc_a,
  input  logic [DATA_W-1:0]  sc_b,
  input  logic               sc_swap,
  input  logic [DATA_W-1:0]  cy_a,
  input  logic [DATA_W-1:0]  cy_b,
  input  logic               cy_swap,
  input  logic [1:0]         se_mode,
  input  logic [SE_W-1:0]    se_prg,
  output logic [DATA_W-1:0]  bank
);

  logic [15:0] pmask, base, mask16, base16, inner, x16;
  logic [DATA_W-1:0] wa, wb;
  logic swp;

  always_comb begin
    pmask  = small_mask ? 16'h000F : 16'h001F;
    base   = 16'(outer_reg >> 1);
    mask16 = pmask >> 1;
    base16 = base >> 1;
    wa     = (pers == PERS_SCAN) ? sc_a : cy_a;
    wb     = (pers == PERS_SCAN) ? sc_b : cy_b;
    swp    = (pers == PERS_SCAN) ? sc_swap : cy_swap;
    inner  = '0;
    x16    = '0;
    bank   = '0;
    if (fix_en) begin
      if (small_mask) bank = DATA_W'({base[15:1], win[0]});
      else            bank = DATA_W'({base[15:2], win});
    end else if (pers == PERS_SER) begin
      if (se_mode[1]) begin
        if (se_mode[0]) inner = win[1] ? 16'hFFFF : 16'(se_prg);
        else            inner = win[1] ? 16'(se_prg) : 16'h0000;
        x16  = mix_bits(inner, mask16, base16);
        bank = DATA_W'({x16[14:0], win[0]});
      end else begin
        x16  = mix_bits(16'(se_prg), mask16, base16);
        bank = DATA_W'({x16[15:1], win});
      end
    end else begin
      unique case (win)
        2'd0: inner = swp ? 16'h00FE : 16'(wa);
        2'd1: inner = 16'(wb);
        2'd2: inner = swp ? 16'(wa) : 16'h00FE;
        default: inner = 16'h00FF;
      endcase
      bank = DATA_W'(mix_bits(inner, pmask, base));
    end
  end

endmodule

// File: rtl/mc_chr_map.sv
module mc_chr_map
  import mc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SE_W   = 5,
  localparam int CHR_W = DATA_W + 1
) (
  input  pers_t                  pers,
  input  logic                   fix_en,
  input  logic                   sz_small,
  input  logic                   sz_mid,
  input  logic [DATA_W-1:0]      outer_reg,
  input  logic [2:0]             slot,
  input  logic [5:0][DATA_W-1:0] sc_chr,
  input  logic                   sc_swap,
  input  logic [7:0][DATA_W-1:0] cy_chr,
  input  logic                   se_4k,
  input  logic [SE_W-1:0]        se_lo,
  input  logic [SE_W-1:0]        se_hi,
  output logic [CHR_W-1:0]       bank
);

  logic [15:0] cmask, cbase, m4, b4, inner, x;
  logic [2:0]  s;

  always_comb begin
    cmask = sz_small ? 16'h001F : (sz_mid ? 16'h007F : 16'h00FF);
    cbase = 16'({outer_reg, 1'b0});
    m4    = cmask >> 2;
    b4    = cbase >> 2;
    s     = slot ^ {sc_swap, 2'b00};
    inner = '0;
    x     = '0;
    bank  = '0;
    if (fix_en) begin
      bank = CHR_W'({cbase[15:3], slot});
    end else if (pers == PERS_SER) begin
      if (se_4k) begin
        x    = mix_bits(16'(slot[2] ? se_hi : se_lo), m4, b4);
        bank = CHR_W'({x[13:0], slot[1:0]});
      end else begin
        x    = mix_bits(16'(se_lo), m4, b4);
        bank = CHR_W'({x[15:1], slot});
      end
    end else begin
      if (pers == PERS_SCAN) begin
        if (!s[2]) inner = 16'({sc_chr[{2'b00, s[1]}][DATA_W-1:1], s[0]});
        else       inner = 16'(sc_chr[3'(s - 3'd2)]);
      end else begin
        inner = 16'(cy_chr[slot]);
      end
      bank = CHR_W'(mix_bits(inner, cmask, cbase));
    end
  end

endmodule

// File: rtl/mc_outer_mapper.sv
module mc_outer_mapper
  import mc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SE_W   = 5,
  parameter int CPU_AW = 16,
  parameter int PPU_AW = 14,
  localparam int CHR_W = DATA_W + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pwr_rst,
  input  logic [CPU_AW-1:0]      cpu_addr,
  input  logic                   cpu_wr,
  input  logic                   cpu_rd,
  input  logic [DATA_W-1:0]      cpu_wdata,
  output logic [DATA_W-1:0]      cpu_rdata,
  input  logic [PPU_AW-1:0]      ppu_addr,
  input  logic [DATA_W-1:0]      sc_prg_a,
  input  logic [DATA_W-1:0]      sc_prg_b,
  input  logic                   sc_prg_swap,
  input  logic [6*DATA_W-1:0]    sc_chr,
  input  logic                   sc_chr_swap,
  input  logic                   sc_mirror,
  input  logic [DATA_W-1:0]      cy_prg_a,
  input  logic [DATA_W-1:0]      cy_prg_b,
  input  logic                   cy_prg_swap,
  input  logic [8*DATA_W-1:0]    cy_chr,
  input  logic [1:0]             cy_mirror,
  input  logic [SE_W-1:0]        se_ctrl,
  input  logic [SE_W-1:0]        se_prg,
  input  logic [SE_W-1:0]        se_chr_lo,
  input  logic [SE_W-1:0]        se_chr_hi,
  output logic [DATA_W-1:0]      prg_bank,
  output logic [CHR_W-1:0]       chr_bank,
  output logic [1:0]             mirror
);

  logic [3:0][DATA_W-1:0] reg_q;
  logic [DATA_W-1:0]      sw_q;
  logic                   win_hit;
  pers_t                  pers;
  mir_t                   mir_sel;
  logic                   unused_bits;

  assign win_hit = (cpu_addr[CPU_AW-1:CPU_AW-4] == 4'h5);
  assign pers    = pers_of(reg_q[0][1:0]);

  mc_outer_regs #(.DATA_W(DATA_W), .NREG(4)) u_regs (
    .clk(clk), .rst(rst), .pwr_rst(pwr_rst),
    .wr_en(cpu_wr && win_hit), .wr_sel(cpu_addr[1:0]), .wr_data(cpu_wdata),
    .regs_o(reg_q), .sw_o(sw_q)
  );

  mc_prg_map #(.DATA_W(DATA_W), .SE_W(SE_W)) u_prg (
    .pers(pers), .fix_en(reg_q[2][7]), .small_mask(reg_q[2][2]),
    .outer_reg(reg_q[1]), .win(cpu_addr[14:13]),
    .sc_a(sc_prg_a), .sc_b(sc_prg_b), .sc_swap(sc_prg_swap),
    .cy_a(cy_prg_a), .cy_b(cy_prg_b), .cy_swap(cy_prg_swap),
    .se_mode(se_ctrl[3:2]), .se_prg(se_prg), .bank(prg_bank)
  );

  mc_chr_map #(.DATA_W(DATA_W), .SE_W(SE_W)) u_chr (
    .pers(pers), .fix_en(reg_q[2][6]), .sz_small(reg_q[2][4]), .sz_mid(reg_q[2][5]),
    .outer_reg(reg_q[0]), .slot(ppu_addr[12:10]),
    .sc_chr(sc_chr), .sc_swap(sc_chr_swap), .cy_chr(cy_chr),
    .se_4k(se_ctrl[4]), .se_lo(se_chr_lo), .se_hi(se_chr_hi), .bank(chr_bank)
  );

  always_comb begin
    unique case (pers)
      PERS_SCAN: mir_sel = sc_mirror ? MIR_HORZ : MIR_VERT;
      PERS_CYC:  mir_sel = mir_t'(cy_mirror);
      default:   mir_sel = mir_t'(se_ctrl[1:0] ^ 2'b10);
    endcase
  end

  assign mirror    = mir_sel;
  assign cpu_rdata = (cpu_rd && win_hit) ? sw_q : '0;

  assign unused_bits = ^{cpu_addr[11:2], ppu_addr, reg_q[3], reg_q[2][3], reg_q[2][1:0]};

endmodule

// File: rtl/mc_outer_mapper_chk.sv
module mc_outer_mapper_chk #(
  parameter int DATA_W = 8,
  parameter int CPU_AW = 16,
  parameter int PPU_AW = 14,
  localparam int CHR_W = DATA_W + 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   pwr_rst,
  input logic [CPU_AW-1:0]      cpu_addr,
  input logic                   cpu_wr,
  input logic [DATA_W-1:0]      cpu_wdata,
  input logic [PPU_AW-1:0]      ppu_addr,
  input logic [DATA_W-1:0]      prg_bank,
  input logic [CHR_W-1:0]       chr_bank,
  input logic [3:0][DATA_W-1:0] reg_q,
  input logic [DATA_W-1:0]      sw_q
);

  logic unused_chk;
  assign unused_chk = ^{cpu_addr, ppu_addr, prg_bank, chr_bank};

  // R1
  reg_write_chk: assert property (@(posedge clk) disable iff (rst || pwr_rst)
    (cpu_wr && cpu_addr[CPU_AW-1:CPU_AW-4] == 4'h5)
      |=> reg_q[$past(cpu_addr[1:0])] == $past(cpu_wdata));

  // R12
  sw_step_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    rst |=> (sw_q == $past(sw_q) + 1'b1) && (reg_q == '0));

  // R12
  pwr_clear_chk: assert property (@(posedge clk)
    pwr_rst |=> (sw_q == '0) && (reg_q == '0));

  // R5
  top_window_chk: assert property (@(posedge clk) disable iff (rst || pwr_rst)
    (reg_q[0][1:0] != 2'b10 && !reg_q[2][7] && cpu_addr[15] && cpu_addr[14:13] == 2'b11)
      |-> prg_bank[3:0] == 4'hF);

  // R7
  fixed_prg_chk: assert property (@(posedge clk) disable iff (rst || pwr_rst)
    reg_q[2][7] |-> prg_bank[0] == cpu_addr[13]);

  // R10
  fixed_chr_chk: assert property (@(posedge clk) disable iff (rst || pwr_rst)
    reg_q[2][6] |-> chr_bank[2:0] == ppu_addr[12:10]);

endmodule

bind mc_outer_mapper mc_outer_mapper_chk #(
  .DATA_W(DATA_W), .CPU_AW(CPU_AW), .PPU_AW(PPU_AW)
) u_chk (.*);

// File: tb/mc_outer_mapper_bench.sv
module mc_outer_mapper_bench;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, pwr_rst, cpu_wr, cpu_rd;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic [13:0] ppu_addr;
  logic [7:0]  sc_prg_a, sc_prg_b, cy_prg_a, cy_prg_b;
  logic        sc_prg_swap, sc_chr_swap, sc_mirror, cy_prg_swap;
  logic [5:0][7:0] sc_chr;
  logic [7:0][7:0] cy_chr;
  logic [1:0]  cy_mirror;
  logic [4:0]  se_ctrl, se_prg, se_chr_lo, se_chr_hi;
  logic [7:0]  prg_bank;
  logic [8:0]  chr_bank;
  logic [1:0]  mirror;

  mc_outer_mapper u_mc_outer_mapper (
    .clk(clk), .rst(rst), .pwr_rst(pwr_rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ppu_addr(ppu_addr),
    .sc_prg_a(sc_prg_a), .sc_prg_b(sc_prg_b), .sc_prg_swap(sc_prg_swap), .sc_chr(sc_chr),
    .sc_chr_swap(sc_chr_swap), .sc_mirror(sc_mirror), .cy_prg_a(cy_prg_a), .cy_prg_b(cy_prg_b),
    .cy_prg_swap(cy_prg_swap), .cy_chr(cy_chr), .cy_mirror(cy_mirror), .se_ctrl(se_ctrl),
    .se_prg(se_prg), .se_chr_lo(se_chr_lo), .se_chr_hi(se_chr_hi),
    .prg_bank(prg_bank), .chr_bank(chr_bank), .mirror(mirror)
  );

  int checks = 0;
  int fails  = 0;
  int mr [4];
  int msw;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_prg(input int w);
    int pand, por, m, a, b, sw, inn, pa, po, x;
    pand = mr[2][2] ? 15 : 31;
    por  = mr[1] >> 1;
    if (mr[2][7]) return mr[2][2] ? (((por >> 1) << 1) | (w & 1)) : (((por >> 2) << 2) | w);
    m = mr[0] & 3;
    if (m == 2) begin
      pa = pand >> 1;
      po = por >> 1;
      if (se_ctrl[3]) begin
        if (se_ctrl[2]) inn = (w >= 2) ? 255 : int'(se_prg);
        else            inn = (w >= 2) ? int'(se_prg) : 0;
        x = (inn & pa) | (po & ~pa);
        return (x * 2 + (w & 1)) & 255;
      end
      x = (int'(se_prg) & pa) | (po & ~pa);
      return ((x >> 1) * 4 + w) & 255;
    end
    a  = (m < 2) ? int'(sc_prg_a) : int'(cy_prg_a);
    b  = (m < 2) ? int'(sc_prg_b) : int'(cy_prg_b);
    sw = (m < 2) ? int'(sc_prg_swap) : int'(cy_prg_swap);
    case (w)
      0: inn = sw ? 254 : a;
      1: inn = b;
      2: inn = sw ? a : 254;
      default: inn = 255;
    endcase
    return ((inn & pand) | (por & ~pand)) & 255;
  endfunction

  function automatic int ref_chr(input int s);
    int cmask, cbase, m, s2, inn, mk, bs, x;
    cmask = mr[2][4] ? 31 : (mr[2][5] ? 127 : 255);
    cbase = mr[0] * 2;
    if (mr[2][6]) return ((cbase >> 3) * 8 + s) & 511;
    m = mr[0] & 3;
    if (m == 2) begin
      mk = cmask >> 2;
      bs = cbase >> 2;
      if (se_ctrl[4]) begin
        x = ((s >= 4 ? int'(se_chr_hi) : int'(se_chr_lo)) & mk) | (bs & ~mk);
        return (x * 4 + (s % 4)) & 511;
      end
      x = (int'(se_chr_lo) & mk) | (bs & ~mk);
      return ((x >> 1) * 8 + s) & 511;
    end
    if (m < 2) begin
      s2 = sc_chr_swap ? (s ^ 4) : s;
      if (s2 < 4) inn = (int'(sc_chr[s2 / 2]) & 254) | (s2 % 2);
      else        inn = int'(sc_chr[s2 - 2]);
    end else begin
      inn = int'(cy_chr[s]);
    end
    return ((inn & cmask) | (cbase & ~cmask)) & 511;
  endfunction

  function automatic int ref_mir();
    int m;
    m = mr[0] & 3;
    if (m < 2) return sc_mirror ? 1 : 0;
    if (m == 3) return int'(cy_mirror);
    return int'(se_ctrl[1:0]) ^ 2;
  endfunction

  task automatic wr_at(input logic [15:0] a, input logic [7:0] v);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = v; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    if (a[15:12] == 4'h5) mr[a[1:0]] = int'(v);
  endtask

  task automatic wr_reg(input int idx, input int v);
    logic [15:0] a;
    a = 16'h5000 | (16'($urandom) & 16'h0FFC) | 16'(idx);
    wr_at(a, 8'(v));
  endtask

  task automatic rand_inner();
    sc_prg_a = 8'($urandom); sc_prg_b = 8'($urandom); sc_prg_swap = 1'($urandom);
    sc_chr_swap = 1'($urandom); sc_mirror = 1'($urandom);
    cy_prg_a = 8'($urandom); cy_prg_b = 8'($urandom); cy_prg_swap = 1'($urandom);
    cy_mirror = 2'($urandom);
    for (int k = 0; k < 6; k++) sc_chr[k] = 8'($urandom);
    for (int k = 0; k < 8; k++) cy_chr[k] = 8'($urandom);
    se_ctrl = 5'($urandom); se_prg = 5'($urandom);
    se_chr_lo = 5'($urandom); se_chr_hi = 5'($urandom);
  endtask

  task automatic check_all(input string pre);
    string pt, ct;
    int m;
    m  = mr[0] & 3;
    pt = mr[2][7] ? "R7" : (m == 2 ? "R3 R6" : "R3 R4 R5");
    ct = mr[2][6] ? "R10" : (m == 2 ? "R9" : "R8");
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      cpu_addr = 16'h8000 | 16'(w << 13) | (16'($urandom) & 16'h1FFF);
      #1;
      chk({pre, " ", pt, " prg"}, int'(prg_bank), ref_prg(w));
    end
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      ppu_addr = 14'(s << 10) | (14'($urandom) & 14'h23FF);
      #1;
      chk({pre, " ", ct, " chr"}, int'(chr_bank), ref_chr(s));
    end
    chk({pre, " R11 mirror"}, int'(mirror), ref_mir());
  endtask

  task automatic check_read();
    @(negedge clk);
    cpu_rd = 1'b1; cpu_addr = 16'h5000 | (16'($urandom) & 16'h0FFF);
    #1;
    chk("R2 read in window", int'(cpu_rdata), msw);
    cpu_addr = 16'h6000;
    #1;
    chk("R2 read outside window", int'(cpu_rdata), 0);
    cpu_rd = 1'b0; cpu_addr = 16'h5001;
    #1;
    chk("R2 no read strobe", int'(cpu_rdata), 0);
  endtask

  task automatic sys_reset(input logic with_write);
    @(negedge clk);
    rst = 1'b1;
    if (with_write) begin
      cpu_wr = 1'b1; cpu_addr = 16'h5002; cpu_wdata = 8'h80;
    end
    @(negedge clk);
    rst = 1'b0; cpu_wr = 1'b0;
    for (int i = 0; i < 4; i++) mr[i] = 0;
    msw = (msw + 1) & 255;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    int r2_list [8];
    r2_list = '{8'h00, 8'h04, 8'h10, 8'h24, 8'h80, 8'h84, 8'h40, 8'h34};
    void'($urandom(32'd2718));
    rst = 1'b0; pwr_rst = 1'b1; cpu_wr = 1'b0; cpu_rd = 1'b0;
    cpu_addr = '0; cpu_wdata = '0; ppu_addr = '0;
    sc_prg_a = '0; sc_prg_b = '0; sc_prg_swap = 1'b0; sc_chr = '0; sc_chr_swap = 1'b0;
    sc_mirror = 1'b0; cy_prg_a = '0; cy_prg_b = '0; cy_prg_swap = 1'b0; cy_chr = '0;
    cy_mirror = '0; se_ctrl = '0; se_prg = '0; se_chr_lo = '0; se_chr_hi = '0;
    for (int i = 0; i < 4; i++) mr[i] = 0;
    msw = 0;
    repeat (3) @(negedge clk);
    pwr_rst = 1'b0;

    // R12 power-on state
    check_read();
    check_all("R12 power-on");

    // R1 writes outside the window are ignored
    rand_inner();
    wr_at(16'h6002, 8'h80);
    wr_at(16'h4FFF, 8'hFF);
    wr_at(16'hD001, 8'hFE);
    check_all("R1 outside-window");

    // R4 directed mask/base
    wr_reg(1, 8'hFF);
    sc_prg_a = 8'h00; sc_prg_swap = 1'b0;
    @(negedge clk); cpu_addr = 16'h8000; #1;
    chk("R4 wide mask base bits", int'(prg_bank), 8'h60);
    wr_reg(2, 8'h04);
    @(negedge clk); cpu_addr = 16'h8123; #1;
    chk("R4 narrow mask base bits", int'(prg_bank), 8'h70);

    // directed sweep over override/mask settings and personalities
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 8; k++) begin
        rand_inner();
        wr_reg(0, ($urandom & 8'hFC) | m);
        wr_reg(1, $urandom & 8'hFF);
        wr_reg(2, r2_list[k]);
        check_all("sweep");
      end
    end

    // constrained random configurations
    for (int n = 0; n < 40; n++) begin
      rand_inner();
      wr_reg(0, $urandom & 8'hFF);
      wr_reg(1, $urandom & 8'hFF);
      wr_reg(2, $urandom & 8'hF4);
      wr_reg(3, $urandom & 8'hFF);
      check_all("random");
    end

    // R12 reset collides with a write; reset wins and switch value steps
    rand_inner();
    wr_reg(0, 8'h03);
    sys_reset(1'b1);
    check_read();
    check_all("R12 reset+write");
    sys_reset(1'b0);
    check_read();
    check_all("R12 second reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule